// File: doc/BRIEF.md
# Pipelined ADC Channel Read Sequencer

This block is an SPI master that reads single samples from a multi-channel successive-approximation converter whose settings take effect with a pipeline delay. The converter starts a conversion when chip select rises at the end of a frame. It goes back to sampling its input by itself once that conversion finishes. The data a frame carries out of the device comes from the settings written two frames earlier. A naive write-then-read therefore returns a sample taken on the previously selected input.

For each request the sequencer sends the settings word that routes the input multiplexer to the requested channel. It then runs follow-up frames whose outbound bits carry no settings. It discards what those early frames return and hands back only the sample that was taken after the new routing was in place. Between frames, chip select stays high for a fixed number of clock cycles, so the device always has time to finish a conversion before the next frame starts.

The block remembers the channel it last programmed. When the fast option is set and a request names that same channel, one follow-up frame is dropped, because the device is already sampling the right input. On the user side the block has a ready/valid request port and a one-cycle response strobe.

Top module: `adcseq_top`

## Requirements
- R1: After reset, and whenever no read is in progress, `req_ready` is high, `spi_cs_n` is high, `spi_sclk` is low and `rsp_valid` is low. A request is taken only in a cycle where both `req_valid` and `req_ready` are high, and chip select falls on the next clock edge.
- R2: Frames use SPI mode 0. The clock idles low and every frame has exactly FRAME_W (default 14) rising clock edges. Each clock half-period lasts SCLK_HALF system clocks. MOSI is sent MSB first and changes only while the clock falls. MISO is sampled as the clock rises.
- R3: The first frame of each read shifts out the settings word. This is CFG_BASE (default 0x3C09) with bits [9:7] replaced by the requested channel number.
- R4: Every later frame of a read shifts out all zeros on MOSI.
- R5: A normal read uses three frames. The response carries the first SAMPLE_W bits received in the third frame. Data from the first two frames is never returned.
- R6: Between the end of one frame and the start of the next, chip select stays high for at least CONV_CYC clock cycles. Inside one read it stays high for exactly CONV_CYC cycles.
- R7: If `fast_mode` is high when a request is accepted, and the requested channel equals the channel last written since reset, the read uses two frames and returns the data of the second. In every other case, including the first read after reset, the read uses three frames.
- R8: `rsp_valid` is high for exactly one cycle, on the edge where chip select rises at the end of the final frame. In that cycle `rsp_data` holds the sample and `rsp_ch` holds the channel that was requested.
- R9: Synchronous reset in the middle of a read returns the block to idle with chip select high. No response is produced, and the remembered channel is cleared, so the next fast-mode read takes three frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| srst | input | 1 | Synchronous reset, active high |
| fast_mode | input | 1 | Allow skipping one follow-up frame when the channel is unchanged |
| req_valid | input | 1 | Read request strobe |
| req_ch | input | CH_W | Channel to read |
| req_ready | output | 1 | High when a request can be accepted |
| rsp_valid | output | 1 | One-cycle strobe marking a returned sample |
| rsp_data | output | SAMPLE_W | Returned sample |
| rsp_ch | output | CH_W | Channel the sample was taken on |
| spi_sclk | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the converter |
| spi_miso | input | 1 | SPI data from the converter |

## Verification
The assertions assume that the converter is already idle when reset is released. For that reason the chip-select rest counter starts out full after reset rather than at zero. They also assume that CONV_CYC is at least one, and that requests are sampled only in cycles where the block reports ready. The bench raises a request only after it has seen `req_ready` high, and drops it one cycle later. After the mid-read reset it waits well over CONV_CYC cycles before issuing the next request. It models the converter's two-frame pipeline on its own, and it keeps its edge-timing monitors quiet while reset is held, so that a frame cut short by reset is not mistaken for a timing fault.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_XFER = 2'd1,
    SEQ_GAP  = 2'd2
  } seq_state_e;

  // Frame length covers both the outbound settings word and the inbound sample.
  function automatic int frame_len(input int cfg_w, input int smp_w);
    return (cfg_w > smp_w) ? cfg_w : smp_w;
  endfunction

  // Insert a channel number into its field of the settings word.
  function automatic logic [31:0] place_channel(input logic [31:0] base,
                                                input logic [31:0] ch,
                                                input int lsb,
                                                input int width);
    logic [31:0] mask;
    mask = ((32'd1 << width) - 32'd1) << lsb;
    return (base & ~mask) | ((ch << lsb) & mask);
  endfunction

  // Index (0-based) of the frame whose inbound data is returned.
  function automatic logic [1:0] final_frame_index(input logic same_channel_fast);
    return same_channel_fast ? 2'd1 : 2'd2;
  endfunction

endpackage

// File: rtl/adcseq_clkdiv.sv
module adcseq_clkdiv #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic srst,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (srst || !en) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);

  generate
    if (HALF > 1) begin : g_spaced
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (srst)
        tick |=> !tick) else $error("tick repeated");  // R2
    end
  endgenerate
endmodule

// File: rtl/adcseq_shifter.sv
module adcseq_shifter #(
  parameter int FW = 14
) (
  input  logic          clk,
  input  logic          srst,
  input  logic          start,
  input  logic [FW-1:0] load_word,
  input  logic          tick,
  input  logic          miso,
  output logic          sclk,
  output logic          mosi,
  output logic          active,
  output logic          frame_end,
  output logic [FW-1:0] rx_word
);
  localparam int BW = (FW > 1) ? $clog2(FW) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(FW - 1);

  logic [FW-1:0] tx_sr;
  logic [BW-1:0] bit_cnt;

  // Named event: the falling clock edge that closes the frame.
  assign frame_end = active && tick && sclk && (bit_cnt == LAST_BIT);
  assign mosi      = tx_sr[FW-1];

  always_ff @(posedge clk) begin
    if (srst) begin
      active  <= 1'b0;
      sclk    <= 1'b0;
      bit_cnt <= '0;
      tx_sr   <= '0;
      rx_word <= '0;
    end else if (start) begin
      active  <= 1'b1;
      sclk    <= 1'b0;
      bit_cnt <= '0;
      tx_sr   <= load_word;
    end else if (active && tick) begin
      if (!sclk) begin
        sclk    <= 1'b1;
        rx_word <= {rx_word[FW-2:0], miso};
      end else begin
        sclk <= 1'b0;
        if (frame_end) begin
          active <= 1'b0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          tx_sr   <= {tx_sr[FW-2:0], 1'b0};
        end
      end
    end
  end

  AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (srst)
    start |-> !active) else $error("frame started over a running frame");  // R2
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int FW       = 14,
  parameter int SAMPLE_W = 14,
  parameter int CFG_W    = 14,
  parameter int CH_W     = 3,
  parameter int CH_LSB   = 7,
  parameter logic [CFG_W-1:0] CFG_BASE = 14'h3C09,
  parameter int CONV_CYC = 120
) (
  input  logic                clk,
  input  logic                srst,
  input  logic                fast_mode,
  input  logic                req_valid,
  input  logic [CH_W-1:0]     req_ch,
  output logic                req_ready,
  input  logic                frame_end,
  input  logic [FW-1:0]       rx_word,
  output logic                start,
  output logic [FW-1:0]       tx_word,
  output logic                cs_n,
  output logic                rsp_valid,
  output logic [SAMPLE_W-1:0] rsp_data,
  output logic [CH_W-1:0]     rsp_ch
);
  localparam int GW = $clog2(CONV_CYC + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(CONV_CYC - 1);
  localparam logic [GW-1:0] GAP_FULL = GW'(CONV_CYC);

  seq_state_e     state;
  logic [CH_W-1:0] cur_ch;
  logic [CH_W-1:0] mem_ch;
  logic            mem_valid;
  logic [1:0]      xfer_idx;
  logic [1:0]      last_idx;
  logic [GW-1:0]   gap_cnt;

  logic            accept;
  logic            fast_hit;
  logic            gap_done;
  logic            more;
  logic [CFG_W-1:0] cfg_word;

  assign req_ready = (state == SEQ_IDLE);
  assign accept    = req_valid && req_ready;
  assign fast_hit  = fast_mode && mem_valid && (mem_ch == req_ch);
  assign gap_done  = (state == SEQ_GAP) && (gap_cnt == GAP_LAST);
  assign more      = (xfer_idx != last_idx);
  assign start     = accept || (gap_done && more);
  assign cfg_word  = CFG_W'(place_channel(32'(CFG_BASE), 32'(req_ch), CH_LSB, CH_W));
  assign tx_word   = accept ? (FW'(cfg_word) << (FW - CFG_W)) : '0;

  always_ff @(posedge clk) begin
    if (srst) begin
      state     <= SEQ_IDLE;
      cs_n      <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_ch    <= '0;
      cur_ch    <= '0;
      mem_ch    <= '0;
      mem_valid <= 1'b0;
      xfer_idx  <= '0;
      last_idx  <= '0;
      gap_cnt   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (accept) begin
            cur_ch    <= req_ch;
            last_idx  <= final_frame_index(fast_hit);
            xfer_idx  <= '0;
            mem_ch    <= req_ch;
            mem_valid <= 1'b1;
            cs_n      <= 1'b0;
            state     <= SEQ_XFER;
          end
        end
        SEQ_XFER: begin
          if (frame_end) begin
            cs_n    <= 1'b1;
            gap_cnt <= '0;
            state   <= SEQ_GAP;
            if (xfer_idx == last_idx) begin
              rsp_valid <= 1'b1;
              rsp_data  <= rx_word[FW-1 -: SAMPLE_W];
              rsp_ch    <= cur_ch;
            end
          end
        end
        SEQ_GAP: begin
          if (gap_done) begin
            if (more) begin
              xfer_idx <= xfer_idx + 1'b1;
              cs_n     <= 1'b0;
              state    <= SEQ_XFER;
            end else begin
              state <= SEQ_IDLE;
            end
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // Rest counter: cycles chip select has been high, saturating; full after reset.
  logic [GW-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (srst) hi_cnt <= GAP_FULL;
    else if (!cs_n) hi_cnt <= '0;
    else if (hi_cnt < GAP_FULL) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_CS_REST: assert property (@(posedge clk) disable iff (srst)
    $fell(cs_n) |-> (hi_cnt >= GAP_FULL)) else $error("chip select rest too short");  // R6
  AST_ACCEPT_OPENS: assert property (@(posedge clk) disable iff (srst)
    (req_valid && req_ready) |=> !cs_n) else $error("accept did not open a frame");  // R1
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (srst)
    rsp_valid |=> !rsp_valid) else $error("response longer than one cycle");  // R8
  AST_RSP_AT_RISE: assert property (@(posedge clk) disable iff (srst)
    rsp_valid |-> $rose(cs_n)) else $error("response not at frame close");  // R8
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (srst)
    !cs_n |-> !req_ready) else $error("ready during a frame");  // R1
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top #(
  parameter int SAMPLE_W  = 14,
  parameter int CFG_W     = 14,
  parameter int CH_W      = 3,
  parameter int CH_LSB    = 7,
  parameter logic [CFG_W-1:0] CFG_BASE = 14'h3C09,
  parameter int SCLK_HALF = 2,
  parameter int CONV_CYC  = 120
) (
  input  logic                clk,
  input  logic                srst,
  input  logic                fast_mode,
  input  logic                req_valid,
  input  logic [CH_W-1:0]     req_ch,
  output logic                req_ready,
  output logic                rsp_valid,
  output logic [SAMPLE_W-1:0] rsp_data,
  output logic [CH_W-1:0]     rsp_ch,
  output logic                spi_sclk,
  output logic                spi_cs_n,
  output logic                spi_mosi,
  input  logic                spi_miso
);
  localparam int FRAME_W = adcseq_pkg::frame_len(CFG_W, SAMPLE_W);
  localparam int EW      = $clog2(FRAME_W + 2);

  logic               sh_active;
  logic               sh_tick;
  logic               sh_start;
  logic               sh_frame_end;
  logic [FRAME_W-1:0] sh_tx_word;
  logic [FRAME_W-1:0] sh_rx_word;

  adcseq_clkdiv #(.HALF(SCLK_HALF)) u_div (
    .clk  (clk),
    .srst (srst),
    .en   (sh_active),
    .tick (sh_tick)
  );

  adcseq_shifter #(.FW(FRAME_W)) u_shift (
    .clk       (clk),
    .srst      (srst),
    .start     (sh_start),
    .load_word (sh_tx_word),
    .tick      (sh_tick),
    .miso      (spi_miso),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .active    (sh_active),
    .frame_end (sh_frame_end),
    .rx_word   (sh_rx_word)
  );

  adcseq_ctrl #(
    .FW       (FRAME_W),
    .SAMPLE_W (SAMPLE_W),
    .CFG_W    (CFG_W),
    .CH_W     (CH_W),
    .CH_LSB   (CH_LSB),
    .CFG_BASE (CFG_BASE),
    .CONV_CYC (CONV_CYC)
  ) u_ctrl (
    .clk       (clk),
    .srst      (srst),
    .fast_mode (fast_mode),
    .req_valid (req_valid),
    .req_ch    (req_ch),
    .req_ready (req_ready),
    .frame_end (sh_frame_end),
    .rx_word   (sh_rx_word),
    .start     (sh_start),
    .tx_word   (sh_tx_word),
    .cs_n      (spi_cs_n),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_ch    (rsp_ch)
  );

  // Edge counter for the frame-length check.
  logic          sclk_prev;
  logic [EW-1:0] edge_cnt;
  always_ff @(posedge clk) begin
    if (srst) begin
      sclk_prev <= 1'b0;
      edge_cnt  <= '0;
    end else begin
      sclk_prev <= spi_sclk;
      if (spi_cs_n) edge_cnt <= '0;
      else if (spi_sclk && !sclk_prev) edge_cnt <= edge_cnt + 1'b1;
    end
  end

  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (srst)
    ($rose(spi_cs_n) && !$past(srst)) |-> (edge_cnt == EW'(FRAME_W)))
    else $error("wrong number of clock edges in frame");  // R2
  AST_CS_SCLK_IDLE: assert property (@(posedge clk) disable iff (srst)
    spi_cs_n |-> !spi_sclk) else $error("clock high while deselected");  // R2
endmodule

// File: tb/adcseq_top_test.sv
module adcseq_top_test;
  localparam int DIV  = 2;
  localparam int CONV = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        srst, fast_mode, req_valid, req_ready, rsp_valid;
  logic [2:0]  req_ch, rsp_ch;
  logic [13:0] rsp_data;
  logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  adcseq_top #(.SCLK_HALF(DIV), .CONV_CYC(CONV)) uut (
    .clk(clk), .srst(srst), .fast_mode(fast_mode), .req_valid(req_valid),
    .req_ch(req_ch), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_ch(rsp_ch), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int errors = 0;
  int rsp_seen = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Converter model: data of a frame comes from the settings written two frames earlier.
  bit          model_on = 1'b0;
  logic [13:0] m_rx = '0, m_tx = '0, m_res = '0;
  logic [2:0]  m_acq = '0;
  int          m_bits = 0;
  int          rise_cnt = 0;
  logic [13:0] words [0:255];
  int          bits_log [0:255];

  assign spi_miso = m_tx[13];

  always @(posedge spi_sclk) if (model_on && !spi_cs_n) begin
    m_rx = {m_rx[12:0], spi_mosi};
    m_bits++;
  end
  always @(negedge spi_sclk) if (model_on && !spi_cs_n) m_tx = m_tx << 1;
  always @(negedge spi_cs_n) if (model_on) begin
    m_tx = m_res; m_rx = '0; m_bits = 0;
  end
  always @(posedge spi_cs_n) if (model_on) begin
    words[rise_cnt % 256]    = m_rx;
    bits_log[rise_cnt % 256] = m_bits;
    m_res = {m_acq, 11'(rise_cnt)};
    rise_cnt++;
    if (m_rx != 14'd0) m_acq = m_rx[9:7];
  end

  // Timing monitors.
  int hi_cycles = 1000;
  int sclk_hi = 0;
  always @(negedge clk) if (model_on) begin
    if (srst) begin
      sclk_hi = 0;
    end else begin
      if (spi_cs_n) hi_cycles++;
      else begin
        if (hi_cycles > 0) chk(hi_cycles >= CONV, "R6 cs rest", hi_cycles, CONV);
        hi_cycles = 0;
      end
      if (spi_sclk) sclk_hi++;
      else begin
        if (sclk_hi > 0) chk(sclk_hi == DIV, "R2 sclk half period", sclk_hi, DIV);
        sclk_hi = 0;
      end
      if (spi_cs_n) chk(spi_sclk == 1'b0, "R2 sclk idle low", spi_sclk, 0);
    end
    if (rsp_valid) rsp_seen++;
  end

  function automatic int exp_cfg(input int ch);
    return (14'h3C09 & ~(7 << 7)) | (ch << 7);
  endfunction

  // Bench memory of the last programmed channel.
  int  b_last = -1;

  task automatic do_read(input int ch, input bit fast);
    int r0, n, waited;
    n = (fast && b_last == ch) ? 2 : 3;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    r0 = rise_cnt;
    req_valid = 1'b1; req_ch = 3'(ch); fast_mode = fast;
    @(negedge clk);
    req_valid = 1'b0;
    chk(spi_cs_n == 1'b0, "R1 cs falls after accept", spi_cs_n, 0);
    waited = 0;
    while (!rsp_valid && waited < 3000) begin @(negedge clk); waited++; end
    chk(rsp_valid == 1'b1, "R8 response arrives", rsp_valid, 1);
    chk(spi_cs_n == 1'b1, "R8 response with cs rise", spi_cs_n, 1);
    chk(rise_cnt - r0 == n, fast ? "R7 frame count" : "R5 frame count", rise_cnt - r0, n);
    chk(int'(rsp_ch) == ch, "R8 response channel", rsp_ch, ch);
    chk(int'(rsp_data[13:11]) == ch, n == 2 ? "R7 sample channel" : "R5 sample channel",
        rsp_data[13:11], ch);
    chk(int'(rsp_data[10:0]) == ((r0 + n - 2) & 11'h7FF), "R5 sample freshness",
        rsp_data[10:0], (r0 + n - 2) & 11'h7FF);
    chk(int'(words[r0 % 256]) == exp_cfg(ch), "R3 settings word", words[r0 % 256], exp_cfg(ch));
    for (int k = 0; k < n; k++) begin
      chk(bits_log[(r0 + k) % 256] == 14, "R2 clock edges per frame", bits_log[(r0 + k) % 256], 14);
      if (k > 0) chk(words[(r0 + k) % 256] == 14'd0, "R4 follow-up frame zero", words[(r0 + k) % 256], 0);
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 single-cycle response", rsp_valid, 0);
    b_last = ch;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int r0, seen0;
    srst = 1'b1; fast_mode = 1'b0; req_valid = 1'b0; req_ch = '0;
    repeat (4) @(posedge clk);
    model_on = 1'b1;
    @(negedge clk);
    srst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(spi_cs_n == 1'b1, "R1 cs high after reset", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R1 sclk low after reset", spi_sclk, 0);
    chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
    repeat (10) @(negedge clk);

    for (int f = 0; f < 2; f++)
      for (int ch = 0; ch < 8; ch++) begin
        do_read(ch, f[0]);
        do_read(ch, f[0]);
      end
    do_read(7, 1'b1); do_read(0, 1'b1); do_read(0, 1'b1); do_read(7, 1'b1);

    // R9: reset in the middle of a read.
    do_read(5, 1'b0);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    r0 = rise_cnt; seen0 = rsp_seen;
    req_valid = 1'b1; req_ch = 3'd5; fast_mode = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (rise_cnt == r0) @(negedge clk);
    while (spi_cs_n) @(negedge clk);
    repeat (9) @(negedge clk);
    srst = 1'b1;
    repeat (2) @(negedge clk);
    srst = 1'b0;
    @(negedge clk);
    chk(spi_cs_n == 1'b1, "R9 cs high after mid-read reset", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R9 sclk low after mid-read reset", spi_sclk, 0);
    chk(req_ready == 1'b1, "R9 idle after mid-read reset", req_ready, 1);
    repeat (40) @(negedge clk);
    chk(rsp_seen == seen0, "R9 no response from aborted read", rsp_seen - seen0, 0);
    b_last = -1;
    do_read(5, 1'b1);
    do_read(5, 1'b1);

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule